// File: doc/BRIEF.md
# PCI Target Write-Request Unloader

This block sits on the user side of an embedded PCI core and empties the core's target-side queues one pending write request at a time. The core drops an active-low request line when it has decoded a target access. It also presents a 4-bit command code and a 3-bit window index naming which of six base address windows matched. A 64-bit window pair only ever reports index 0, 2 or 4. The unloader latches the command and window index when it first sees the request. It then pulses an active-low address-read strobe to pull the start address out of the core's address queue, one 16-bit word per cycle, lowest word first. Two words are read for a 32-bit address, and four when the first word flags a dual-address cycle.

All queue traffic shares one 18-bit bus, and the meaning of the top two bits depends on the phase. In an address word they carry the dual-address flag (bit 16) and the burst flag (bit 17). In a data word they carry two write enables. Once the header has been presented, the unloader reads write data with an active-low data-read strobe, gated by the queue's active-low empty and almost-empty flags so that it never reads an empty queue. When the request line is released it returns to idle and waits for the next request. Every signal is synchronous to one queue-side clock. The strobes are registered, and the queue answers a strobe on the bus in the cycle after it, so each word is captured one cycle after its strobe.

Top module: `tgt_fifo_drain`

## Requirements
- R1: While reset is asserted and after its release until a request arrives, addr_rd_n and data_rd_n are high and hdr_valid and wd_valid are low.
- R2: hdr_op and hdr_win hold the op_in and win_in values sampled at the edge where the idle unloader first sees req_n low; changes on those inputs later in the request have no effect on the header.
- R3: Each request drives addr_rd_n low for exactly 2 cycles, or exactly 4 cycles when bit 16 of the first address word is 1.
- R4: The header gives hdr_addr built from bits [15:0] of the address words with the first word lowest, and upper 32 bits zero for a 2-word address. hdr_dac is bit 16 of the first word and hdr_burst is bit 17 of the first word. hdr_valid is high for exactly one cycle, rising at the third rising edge after the edge that samples req_n low (the fifth for a 4-word address).
- R5: For each cycle with data_rd_n low, wd_valid rises at the second following rising edge, with wd_data = bus bits [15:0] and wd_be = bus bits [17:16] of the word the queue returned, in queue order.
- R6: data_rd_n is driven low only at an edge where empty_n is sampled high, so the queue is never read while empty.
- R7: If aempty_n is sampled low at an edge while data_rd_n is already low, data_rd_n goes high at that edge (single-beat reads). While aempty_n and empty_n are high, data reads run on consecutive cycles.
- R8: addr_rd_n and data_rd_n are never low in the same cycle, and data reads start only after the header has been presented.
- R9: When req_n is sampled high during the data phase the unloader returns to idle, and a later request is handled from the start again.
- R10: data_rd_n is driven high at every edge where req_n is sampled high, so data waiting in the queue without a request is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Queue-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 1 | Active-low pending target request |
| op_in | input | 4 | PCI command code, valid while req_n is low |
| win_in | input | 3 | Matching base address window index, valid while req_n is low |
| nbus | input | 18 | Shared address/data word from the queues |
| empty_n | input | 1 | Active-low write-data queue empty flag |
| aempty_n | input | 1 | Active-low write-data queue almost-empty flag |
| addr_rd_n | output | 1 | Active-low address queue read strobe |
| data_rd_n | output | 1 | Active-low write-data queue read strobe |
| hdr_valid | output | 1 | One-cycle header valid pulse |
| hdr_addr | output | 64 | Assembled start address |
| hdr_dac | output | 1 | Dual-address flag of the request |
| hdr_burst | output | 1 | Burst flag of the request |
| hdr_op | output | 4 | Latched command code |
| hdr_win | output | 3 | Latched window index |
| wd_valid | output | 1 | Write data word valid |
| wd_data | output | 16 | Write data |
| wd_be | output | 2 | Write enables for the word |

## Verification
The header is due exactly three rising edges after the edge that samples the request, or five for a dual-address request. The bench counts falling edges from the moment it lowers req_n and compares that count with 4 or 6. Each data word is due two rising edges after the edge that lowers data_rd_n. The monitor keeps a two-deep history of the strobe sampled at falling edges and checks that every wd_valid lines up with it. It pops the expected data from the scoreboard queue only at that point. The queue model in the bench updates the empty and almost-empty flags one edge after each pop, so the gating rules are exercised under the same flag latency the unloader is built for.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } tfd_state_t;
endpackage

// File: rtl/tfd_seq.sv
module tfd_seq
  import tfd_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int WIN_W  = 3,
  parameter int MAX_AW = 4,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_n,
  input  logic [CMD_W-1:0] op_in,
  input  logic [WIN_W-1:0] win_in,
  input  logic             empty_n,
  input  logic             aempty_n,
  input  logic             dual_now,
  input  logic             addr_done,
  output logic             start,
  output logic             addr_rd_n,
  output logic             data_rd_n,
  output logic             cap_addr,
  output logic             cap_data,
  output logic [CMD_W-1:0] hdr_op,
  output logic [WIN_W-1:0] hdr_win
);
  localparam logic [CNT_W-1:0] LIM_DUAL = CNT_W'(MAX_AW);
  localparam logic [CNT_W-1:0] LIM_SGL  = CNT_W'(MAX_AW / 2);

  tfd_state_t       st_q, st_d;
  logic [CNT_W-1:0] ai_q, ai_d;
  logic [CNT_W-1:0] limit;
  logic             aen_d, den_d;

  assign limit = dual_now ? LIM_DUAL : LIM_SGL;

  always_comb begin
    st_d  = st_q;
    ai_d  = ai_q;
    aen_d = 1'b1;
    den_d = 1'b1;
    start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!req_n) begin
          st_d  = ST_ADDR;
          start = 1'b1;
          aen_d = 1'b0;
          ai_d  = CNT_W'(1);
        end
      end
      ST_ADDR: begin
        if (addr_done) begin
          st_d = ST_DATA;
        end else if (ai_q < limit) begin
          aen_d = 1'b0;
          ai_d  = ai_q + CNT_W'(1);
        end
      end
      ST_DATA: begin
        if (req_n) begin
          st_d = ST_IDLE;
        end else if (empty_n && (aempty_n || data_rd_n)) begin
          den_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ai_q      <= '0;
      addr_rd_n <= 1'b1;
      data_rd_n <= 1'b1;
      cap_addr  <= 1'b0;
      cap_data  <= 1'b0;
      hdr_op    <= '0;
      hdr_win   <= '0;
    end else begin
      st_q      <= st_d;
      ai_q      <= ai_d;
      addr_rd_n <= aen_d;
      data_rd_n <= den_d;
      cap_addr  <= ~addr_rd_n;
      cap_data  <= ~data_rd_n;
      if (start) begin
        hdr_op  <= op_in;
        hdr_win <= win_in;
      end
    end
  end
endmodule

// File: rtl/tfd_addr_asm.sv
module tfd_addr_asm #(
  parameter int NB_W   = 18,
  parameter int MAX_AW = 4,
  parameter int CNT_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         cap_addr,
  input  logic [NB_W-1:0]              nbus,
  output logic                         dual_now,
  output logic                         addr_done,
  output logic                         hdr_valid,
  output logic [MAX_AW*(NB_W-2)-1:0]   hdr_addr,
  output logic                         hdr_dac,
  output logic                         hdr_burst
);
  localparam int HALF_W = NB_W - 2;
  localparam logic [CNT_W-1:0] LIM_DUAL = CNT_W'(MAX_AW);
  localparam logic [CNT_W-1:0] LIM_SGL  = CNT_W'(MAX_AW / 2);

  logic [CNT_W-1:0]  acap;
  logic [CNT_W-1:0]  need;
  logic              first, dual_q, burst_q;
  logic [HALF_W-1:0] word_q [MAX_AW];

  assign first     = cap_addr && (acap == '0);
  assign dual_now  = dual_q | (first & nbus[HALF_W]);
  assign need      = dual_now ? LIM_DUAL : LIM_SGL;
  assign addr_done = cap_addr && ((acap + CNT_W'(1)) == need);
  assign hdr_dac   = dual_q;
  assign hdr_burst = burst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acap      <= '0;
      dual_q    <= 1'b0;
      burst_q   <= 1'b0;
      hdr_valid <= 1'b0;
    end else begin
      hdr_valid <= addr_done;
      if (start) begin
        acap    <= '0;
        dual_q  <= 1'b0;
        burst_q <= 1'b0;
      end else if (cap_addr) begin
        acap <= acap + CNT_W'(1);
        if (first) begin
          dual_q  <= nbus[HALF_W];
          burst_q <= nbus[HALF_W+1];
        end
      end
    end
  end

  for (genvar w = 0; w < MAX_AW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (start) begin
        word_q[w] <= '0;
      end else if (cap_addr && (acap == CNT_W'(w))) begin
        word_q[w] <= nbus[HALF_W-1:0];
      end
    end
    assign hdr_addr[w*HALF_W +: HALF_W] = word_q[w];
  end
endmodule

// File: rtl/tfd_wcap.sv
module tfd_wcap #(
  parameter int NB_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_data,
  input  logic [NB_W-1:0]   nbus,
  output logic              wd_valid,
  output logic [NB_W-3:0]   wd_data,
  output logic [1:0]        wd_be
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_valid <= 1'b0;
      wd_data  <= '0;
      wd_be    <= '0;
    end else begin
      wd_valid <= cap_data;
      if (cap_data) begin
        wd_data <= nbus[NB_W-3:0];
        wd_be   <= nbus[NB_W-1:NB_W-2];
      end
    end
  end
endmodule

// File: rtl/tgt_fifo_drain.sv
module tgt_fifo_drain #(
  parameter int NB_W   = 18,
  parameter int CMD_W  = 4,
  parameter int WIN_W  = 3,
  parameter int MAX_AW = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_n,
  input  logic [CMD_W-1:0]            op_in,
  input  logic [WIN_W-1:0]            win_in,
  input  logic [NB_W-1:0]             nbus,
  input  logic                        empty_n,
  input  logic                        aempty_n,
  output logic                        addr_rd_n,
  output logic                        data_rd_n,
  output logic                        hdr_valid,
  output logic [MAX_AW*(NB_W-2)-1:0]  hdr_addr,
  output logic                        hdr_dac,
  output logic                        hdr_burst,
  output logic [CMD_W-1:0]            hdr_op,
  output logic [WIN_W-1:0]            hdr_win,
  output logic                        wd_valid,
  output logic [NB_W-3:0]             wd_data,
  output logic [1:0]                  wd_be
);
  localparam int CNT_W = $clog2(MAX_AW + 1);

  logic [1:0] rst_sync;
  logic       rst_s_n;
  logic       start, cap_addr, cap_data, dual_now, addr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  tfd_seq #(.CMD_W(CMD_W), .WIN_W(WIN_W), .MAX_AW(MAX_AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .req_n(req_n), .op_in(op_in), .win_in(win_in),
    .empty_n(empty_n), .aempty_n(aempty_n), .dual_now(dual_now), .addr_done(addr_done),
    .start(start), .addr_rd_n(addr_rd_n), .data_rd_n(data_rd_n),
    .cap_addr(cap_addr), .cap_data(cap_data), .hdr_op(hdr_op), .hdr_win(hdr_win)
  );

  tfd_addr_asm #(.NB_W(NB_W), .MAX_AW(MAX_AW), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_s_n), .start(start), .cap_addr(cap_addr), .nbus(nbus),
    .dual_now(dual_now), .addr_done(addr_done), .hdr_valid(hdr_valid),
    .hdr_addr(hdr_addr), .hdr_dac(hdr_dac), .hdr_burst(hdr_burst)
  );

  tfd_wcap #(.NB_W(NB_W)) u_wcap (
    .clk(clk), .rst_n(rst_s_n), .cap_data(cap_data), .nbus(nbus),
    .wd_valid(wd_valid), .wd_data(wd_data), .wd_be(wd_be)
  );
endmodule

// File: rtl/tfd_chk.sv
module tfd_chk (
  input logic clk,
  input logic rst_n,
  input logic req_n,
  input logic empty_n,
  input logic aempty_n,
  input logic addr_rd_n,
  input logic data_rd_n,
  input logic hdr_valid,
  input logic hdr_dac,
  input logic wd_valid
);
  logic       rd_d1, rd_d2;
  logic [2:0] acnt;
  logic       hdr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d1    <= 1'b0;
      rd_d2    <= 1'b0;
      acnt     <= '0;
      hdr_seen <= 1'b0;
    end else begin
      rd_d1 <= ~data_rd_n;
      rd_d2 <= rd_d1;
      if (hdr_valid)       acnt <= '0;
      else if (!addr_rd_n) acnt <= acnt + 3'd1;
      if (!addr_rd_n)      hdr_seen <= 1'b0;
      else if (hdr_valid)  hdr_seen <= 1'b1;
    end
  end

  // R3
  addr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (acnt == (hdr_dac ? 3'd4 : 3'd2)));

  // R4
  hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R5
  data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid == rd_d2);

  // R6
  empty_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |=> data_rd_n);

  // R7
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!aempty_n && !data_rd_n) |=> data_rd_n);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!addr_rd_n && !data_rd_n));

  // R8
  data_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd_n |-> hdr_seen);

  // R10
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |=> data_rd_n);
endmodule

bind tgt_fifo_drain tfd_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .req_n(req_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .addr_rd_n(addr_rd_n), .data_rd_n(data_rd_n), .hdr_valid(hdr_valid),
  .hdr_dac(hdr_dac), .wd_valid(wd_valid)
);

// File: tb/tgt_fifo_drain_tb_top.sv
`timescale 1ns/1ps
module tgt_fifo_drain_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_n;
  logic [3:0]  op_in;
  logic [2:0]  win_in;
  logic [17:0] nbus;
  logic        empty_n, aempty_n;
  logic        addr_rd_n, data_rd_n, hdr_valid, hdr_dac, hdr_burst, wd_valid;
  logic [63:0] hdr_addr;
  logic [3:0]  hdr_op;
  logic [2:0]  hdr_win;
  logic [15:0] wd_data;
  logic [1:0]  wd_be;

  int n_cmp = 0, n_bad = 0;
  int overrd = 0, r6bad = 0, r7bad = 0, both_low = 0, stream_seen = 0, acnt = 0;
  logic [17:0] aq[$], dq[$], wq[$];
  logic [72:0] hq[$];
  logic [1:0]  hist = 2'b00;
  logic        prev_den = 1'b0, prev_aem = 1'b0, prev_emp = 1'b0;

  always #5 clk = ~clk;

  tgt_fifo_drain dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .op_in(op_in), .win_in(win_in),
    .nbus(nbus), .empty_n(empty_n), .aempty_n(aempty_n),
    .addr_rd_n(addr_rd_n), .data_rd_n(data_rd_n), .hdr_valid(hdr_valid),
    .hdr_addr(hdr_addr), .hdr_dac(hdr_dac), .hdr_burst(hdr_burst),
    .hdr_op(hdr_op), .hdr_win(hdr_win), .wd_valid(wd_valid),
    .wd_data(wd_data), .wd_be(wd_be)
  );

  task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Queue model: a strobe sampled low at an edge pops one word onto the bus; flags follow one edge later.
  initial begin
    nbus = 18'h2A5A5; empty_n = 1'b0; aempty_n = 1'b0;
    forever begin
      @(posedge clk);
      if (!addr_rd_n) begin
        if (aq.size() != 0) nbus <= aq.pop_front();
      end else if (!data_rd_n) begin
        if (dq.size() == 0) overrd++;
        else nbus <= dq.pop_front();
      end else begin
        nbus <= 18'h2A5A5;
      end
      empty_n  <= (dq.size() != 0);
      aempty_n <= (dq.size() > 4);
    end
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!addr_rd_n && !data_rd_n) both_low++;
        if (!data_rd_n && !prev_emp) r6bad++;
        if (!data_rd_n && prev_den && !prev_aem) r7bad++;
        if (!data_rd_n && prev_den && prev_aem) stream_seen++;
        if (!addr_rd_n) acnt++;
        if (wd_valid || hist[1])
          chk(wd_valid == hist[1], "R5 data timing", 80'(wd_valid), 80'(hist[1]));
        if (wd_valid) begin
          if (wq.size() == 0) chk(1'b0, "R5 unexpected data", 80'({wd_be, wd_data}), 80'h0);
          else begin
            logic [17:0] ew;
            ew = wq.pop_front();
            chk({wd_be, wd_data} == ew, "R5 data word", 80'({wd_be, wd_data}), 80'(ew));
          end
        end
        if (hdr_valid) begin
          if (hq.size() == 0) chk(1'b0, "R4 unexpected header", 80'(hdr_addr), 80'h0);
          else begin
            logic [72:0] eh;
            eh = hq.pop_front();
            chk({hdr_op, hdr_win, hdr_burst, hdr_dac, hdr_addr} == eh, "R2/R4 header",
                80'({hdr_op, hdr_win, hdr_burst, hdr_dac, hdr_addr}), 80'(eh));
            chk(acnt == (eh[64] ? 4 : 2), "R3 address reads", 80'(acnt), 80'(eh[64] ? 4 : 2));
          end
          acnt = 0;
        end
        hist     = {hist[0], ~data_rd_n};
        prev_den = ~data_rd_n;
        prev_aem = aempty_n;
        prev_emp = empty_n;
      end
    end
  end

  task automatic run_txn(input logic [3:0] op, input logic [2:0] win, input logic [63:0] a,
                         input logic dac, input logic burst, input int n, input bit trickle);
    logic [17:0] w;
    int lat;
    @(negedge clk);
    op_in = op; win_in = win;
    aq.push_back({burst, dac, a[15:0]});
    aq.push_back({2'b00, a[31:16]});
    if (dac) begin
      aq.push_back({2'b00, a[47:32]});
      aq.push_back({2'b00, a[63:48]});
    end
    hq.push_back({op, win, burst, dac, (dac ? a : {32'h0, a[31:0]})});
    for (int k = 0; k < n; k++) begin
      w = {2'(k + int'(op)), a[15:0] ^ 16'(k * 4369)};
      wq.push_back(w);
      if (!trickle) dq.push_back(w);
    end
    req_n = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin op_in = ~op; win_in = 3'd7; end
    end while (!hdr_valid && lat < 20);
    chk(lat == (dac ? 6 : 4), "R4 header latency", 80'(lat), 80'(dac ? 6 : 4));
    if (trickle) begin
      for (int k = 0; k < n; k++) begin
        repeat (3) @(negedge clk);
        dq.push_back({2'(k + int'(op)), a[15:0] ^ 16'(k * 4369)});
      end
    end
    while (dq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    req_n = 1'b1;
    op_in = 4'h0; win_in = 3'd0;
    repeat (3) @(negedge clk);
    chk(addr_rd_n && data_rd_n, "R9 back to idle", 80'({addr_rd_n, data_rd_n}), 80'h3);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 80'h0, 80'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_n = 1'b1; op_in = '0; win_in = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(addr_rd_n && data_rd_n && !hdr_valid && !wd_valid, "R1 in reset",
        80'({addr_rd_n, data_rd_n, hdr_valid, wd_valid}), 80'hC);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 after release
    chk(addr_rd_n && data_rd_n && !hdr_valid && !wd_valid, "R1 after reset",
        80'({addr_rd_n, data_rd_n, hdr_valid, wd_valid}), 80'hC);

    run_txn(4'h7, 3'd0, 64'h0000_0000_1234_ABCD, 1'b0, 1'b1, 3, 1'b0);
    run_txn(4'h6, 3'd2, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 12, 1'b0);
    run_txn(4'h7, 3'd5, 64'h0000_0000_FFFF_0000, 1'b0, 1'b0, 5, 1'b1);
    run_txn(4'hF, 3'd4, 64'hDEAD_BEEF_0000_0001, 1'b1, 1'b1, 1, 1'b0);

    // R10: data waiting with no request stays in the queue
    @(negedge clk);
    for (int k = 0; k < 5; k++) dq.push_back(18'h1_0000 + 18'(k));
    repeat (10) @(negedge clk);
    chk(dq.size() == 5, "R10 queue untouched", 80'(dq.size()), 80'd5);
    chk(data_rd_n && !wd_valid, "R10 no read strobe", 80'({data_rd_n, wd_valid}), 80'h2);
    dq.delete();
    repeat (3) @(negedge clk);

    chk(overrd == 0 && r6bad == 0, "R6 empty gating", 80'(overrd + r6bad), 80'h0);
    chk(r7bad == 0, "R7 single beat", 80'(r7bad), 80'h0);
    chk(stream_seen > 0, "R7 streaming", 80'(stream_seen), 80'h1);
    chk(both_low == 0, "R8 strobe exclusive", 80'(both_low), 80'h0);
    chk(hq.size() == 0 && wq.size() == 0, "R4/R5 all delivered",
        80'(hq.size() + wq.size()), 80'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule